// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block lets a host on a two-wire serial bus (I2C-style, open-drain data line) read and write a bank of byte-wide configuration registers. It runs wholly in one free-running system clock domain. Both bus lines are first synchronized. SCL then passes through a persistence filter that takes out short pulses and adds a fixed delay. SDA is delayed by the same amount, so START and STOP detection stays aligned with the filtered clock.

A transfer opens with a START and a 7-bit device address. The upper six bits of that address are fixed. The lowest bit follows a strap input, so two copies can sit on one bus. In a write, the first byte after the address loads an internal register pointer, and each later byte is written to the pointed register before the pointer steps on. In a read, bytes come out of the pointed register with the same auto-increment. The usual pattern is to write the pointer, issue a repeated START and read.

The register bank sits outside the block. Writes leave the block as a one-cycle strobe carrying an address and data. Reads use an address output that always shows the pointer, and a data input that the bank drives combinationally.

Top module: `twr_reg_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal binary 100110 followed by the level of `addr_strap`, sent MSB first. It acknowledges by driving SDA low (`sda_oe`=1) for the whole ninth SCL clock. The eighth bit selects the direction: 1 for read, 0 for write.
- R2: An address byte that does not match gets no acknowledge. SDA stays released for the rest of that transfer, and the transfer produces no register write.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Clocked bus traffic that no START has preceded is ignored: no acknowledge and no write.
- R4: In a write transfer, the first data byte loads the pointer. Each later byte produces exactly one single-cycle `reg_wr_en` pulse, carrying `reg_wr_addr` equal to the pointer and `reg_wr_data` equal to the byte, after which the pointer goes up by one. Every byte of a matched write is acknowledged.
- R5: In a read transfer, each byte is sent MSB first from the register at the pointer, and the pointer then goes up by one. A pointer of 0x00 followed by 28 reads returns registers 0x00 to 0x1B in order.
- R6: A repeated START, with no STOP before it, ends the current transfer and opens a new address phase. The pointer keeps its value across it.
- R7: The pointer wraps from 0xFF to 0x00, for both writes and reads.
- R8: A pulse on SCL lasting two system clocks or less, at either level, is removed by the filter. Such a pulse neither shifts a bit nor disturbs the data.
- R9: `sda_oe` changes only while the filtered SCL is low, or in response to a START or STOP. After the host answers a read byte with NACK, SDA stays released until the next START or STOP.
- R10: Once reset is released, SDA is released (`sda_oe`=0) and `reg_wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_strap | input | 1 | Lowest bit of the device address |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | PTR_W (8) | Register written by the strobe |
| reg_wr_data | output | 8 | Byte written by the strobe |
| reg_rd_addr | output | PTR_W (8) | Current pointer, the register to be read |
| reg_rd_data | input | 8 | Contents of the register at `reg_rd_addr` |

## Verification
A corrupted bit counter or shift register shows up within one byte: the acknowledge lands on the wrong clock, or a byte arrives shifted on the write port or on the bus. A wrong pointer appears on `reg_wr_addr` at the next strobe, or as a wrong first byte in the next read. The scoreboard catches both. A filter that passes a short pulse adds a spurious bit, which shows as a missing acknowledge or misaligned data on the very next byte. A state machine that fails to go quiet after a NACK or a non-matching address is caught by clocking an extra bit and checking that the data line stays high.

// File: rtl/twr_pkg.sv
package twr_pkg;

   localparam logic [5:0] DEV_PREFIX = 6'b100110;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_A,
      ST_WR,
      ST_ACK_W,
      ST_RD,
      ST_RD_ACK,
      ST_WAIT
   } twr_state_e;

endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= '1;
      else        ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/twr_line_filter.sv
module twr_line_filter #(
   parameter int FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_f,
   output logic sda_f
);
   localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);

   logic [CW-1:0] cnt;

   // SCL must differ from the filtered level for FILT_LEN clocks in a row
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_f <= 1'b1;
         cnt   <= '0;
      end else if (scl_s != scl_f) begin
         if (cnt == CW'(FILT_LEN - 1)) begin
            scl_f <= scl_s;
            cnt   <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         cnt <= '0;
      end
   end

   // SDA delayed by the same number of clocks
   generate
      if (FILT_LEN == 1) begin : g_dly_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sda_f <= 1'b1;
            else        sda_f <= sda_s;
         end
      end else begin : g_dly_line
         logic [FILT_LEN-1:0] dly;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dly <= '1;
            else        dly <= {dly[FILT_LEN-2:0], sda_s};
         end
         assign sda_f = dly[FILT_LEN-1];
      end
   endgenerate

   generate
      if (FILT_LEN >= 2) begin : g_chk
         // R8: the filtered clock moves only after the input held the new level
         a_r8_filter_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (scl_f != $past(scl_f)) |-> (($past(scl_s) == scl_f) && ($past(scl_s, 2) == scl_f)));
      end
   endgenerate
endmodule

// File: rtl/twr_cond_detect.sv
module twr_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_rise  =  scl_f & ~scl_q;
   assign scl_fall  = ~scl_f &  scl_q;
   assign start_det =  scl_f &  scl_q &  sda_q & ~sda_f;
   assign stop_det  =  scl_f &  scl_q & ~sda_q &  sda_f;
endmodule

// File: rtl/twr_fsm.sv
module twr_fsm
   import twr_pkg::*;
#(
   parameter int PTR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic             sda_f,
   input  logic             addr_strap,
   input  logic [7:0]       reg_rd_data,
   output logic             sda_oe,
   output logic             reg_wr_en,
   output logic [PTR_W-1:0] reg_wr_addr,
   output logic [7:0]       reg_wr_data,
   output logic [PTR_W-1:0] reg_rd_addr
);
   localparam logic [3:0] LAST_BIT = 4'd8;

   twr_state_e       state;
   logic [3:0]       bitcnt;
   logic [7:0]       shreg;
   logic             rw;
   logic             first;
   logic             ack_seen;
   logic [PTR_W-1:0] ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         bitcnt      <= '0;
         shreg       <= '0;
         rw          <= 1'b0;
         first       <= 1'b0;
         ack_seen    <= 1'b0;
         ptr         <= '0;
         sda_oe      <= 1'b0;
         reg_wr_en   <= 1'b0;
         reg_wr_addr <= '0;
         reg_wr_data <= '0;
      end else begin
         reg_wr_en <= 1'b0;
         if (start_det) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR: begin
                  if (scl_rise && bitcnt != LAST_BIT) begin
                     shreg  <= {shreg[6:0], sda_f};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == LAST_BIT) begin
                     if (shreg[7:1] == {DEV_PREFIX, addr_strap}) begin
                        sda_oe <= 1'b1;
                        rw     <= shreg[0];
                        state  <= ST_ACK_A;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_ACK_A: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (rw) begin
                        shreg  <= reg_rd_data;
                        sda_oe <= ~reg_rd_data[7];
                        state  <= ST_RD;
                     end else begin
                        sda_oe <= 1'b0;
                        first  <= 1'b1;
                        state  <= ST_WR;
                     end
                  end
               end
               ST_WR: begin
                  if (scl_rise && bitcnt != LAST_BIT) begin
                     shreg  <= {shreg[6:0], sda_f};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == LAST_BIT) begin
                     sda_oe <= 1'b1;
                     state  <= ST_ACK_W;
                     if (first) begin
                        ptr   <= shreg[PTR_W-1:0];
                        first <= 1'b0;
                     end else begin
                        reg_wr_en   <= 1'b1;
                        reg_wr_addr <= ptr;
                        reg_wr_data <= shreg;
                        ptr         <= ptr + 1'b1;
                     end
                  end
               end
               ST_ACK_W: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     bitcnt <= '0;
                     state  <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_rise && bitcnt != LAST_BIT) begin
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bitcnt == LAST_BIT) begin
                        sda_oe <= 1'b0;
                        ptr    <= ptr + 1'b1;
                        state  <= ST_RD_ACK;
                     end else begin
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     ack_seen <= ~sda_f;
                  end else if (scl_fall) begin
                     if (ack_seen) begin
                        shreg  <= reg_rd_data;
                        sda_oe <= ~reg_rd_data[7];
                        bitcnt <= '0;
                        state  <= ST_RD;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_WAIT;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign reg_rd_addr = ptr;

   // R10: an idle slave never holds the data line
   a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   // R4: write strobe lasts a single cycle
   a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> !reg_wr_en);

   // R4: every committed byte is acknowledged on the bus
   a_r4_strobe_acked: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> sda_oe);

   // R7: the pointer has stepped past the written register, wrapping at the top
   a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> (reg_rd_addr == PTR_W'(reg_wr_addr + 1'b1)));
endmodule

// File: rtl/twr_reg_slave.sv
module twr_reg_slave #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3,
   parameter int PTR_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   input  logic             addr_strap,
   output logic             reg_wr_en,
   output logic [PTR_W-1:0] reg_wr_addr,
   output logic [7:0]       reg_wr_data,
   output logic [PTR_W-1:0] reg_rd_addr,
   input  logic [7:0]       reg_rd_data
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("twr_reg_slave: SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("twr_reg_slave: FILT_LEN must be at least 1");
      end
      if (PTR_W < 1 || PTR_W > 8) begin : g_bad_ptr
         $error("twr_reg_slave: PTR_W must lie in 1..8");
      end
   endgenerate

   logic scl_s, sda_s, scl_f, sda_f;
   logic scl_rise, scl_fall, start_det, stop_det;

   twr_sync #(.STAGES(SYNC_STAGES)) i_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));

   twr_sync #(.STAGES(SYNC_STAGES)) i_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   twr_line_filter #(.FILT_LEN(FILT_LEN)) i_filter (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_f(scl_f), .sda_f(sda_f));

   twr_cond_detect i_cond (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   twr_fsm #(.PTR_W(PTR_W)) i_fsm (
      .clk(clk), .rst_n(rst_n),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det),
      .sda_f(sda_f), .addr_strap(addr_strap),
      .reg_rd_data(reg_rd_data), .sda_oe(sda_oe),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
      .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr));

   // R9: the data line moves only while the filtered clock is low, or on START/STOP
   a_r9_oe_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> (!scl_f || $past(start_det || stop_det)));
endmodule

// File: tb/test_twr_reg_slave.sv
module test_twr_reg_slave;
   localparam int HB = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_scl = 1'b1;
   logic       host_sda = 1'b1;
   logic       addr_strap = 1'b1;
   logic       sda_bus;
   logic       sda_oe, reg_wr_en;
   logic [7:0] reg_wr_addr, reg_wr_data, reg_rd_addr, reg_rd_data;

   logic [7:0] regs    [0:255];
   logic [7:0] exp_mem [0:255];

   typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_item_t;
   wr_item_t sb_q[$];

   int n_tests = 0;
   int n_fail  = 0;
   int wr_cnt  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   assign sda_bus = host_sda & ~sda_oe;

   twr_reg_slave i_twr_reg_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_bus),
      .sda_oe(sda_oe), .addr_strap(addr_strap),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data));

   // register bank model
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) regs[i] <= 8'((i * 37 + 5) & 8'hFF);
      end else if (reg_wr_en) begin
         regs[reg_wr_addr] <= reg_wr_data;
      end
   end
   assign reg_rd_data = regs[reg_rd_addr];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (reg_wr_en) begin
            wr_cnt++;
            if (sb_q.size() == 0) begin
               check(1'b0, "R4", "unexpected write strobe", int'(reg_wr_addr), 0);
            end else begin
               wr_item_t it;
               it = sb_q.pop_front();
               check(reg_wr_addr == it.a, "R4", "write address", int'(reg_wr_addr), int'(it.a));
               check(reg_wr_data == it.d, "R4", "write data", int'(reg_wr_data), int'(it.d));
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
         report();
         $finish;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      host_sda = 1'b1; tick(HB);
      host_scl = 1'b1; tick(2 * HB);
      host_sda = 1'b0; tick(2 * HB);
      host_scl = 1'b0; tick(HB);
   endtask

   task automatic bus_stop();
      host_sda = 1'b0; tick(HB);
      host_scl = 1'b1; tick(2 * HB);
      host_sda = 1'b1; tick(2 * HB);
   endtask

   task automatic send_bit(input logic b, input bit glitch);
      host_sda = b;
      if (glitch) begin
         tick(3); host_scl = 1'b1; tick(2); host_scl = 1'b0; tick(HB - 5);
      end else tick(HB);
      host_scl = 1'b1;
      if (glitch) begin
         tick(8); host_scl = 1'b0; tick(2); host_scl = 1'b1; tick(2 * HB - 10);
      end else tick(2 * HB);
      host_scl = 1'b0; tick(HB);
   endtask

   task automatic recv_bit(output logic b);
      host_sda = 1'b1; tick(HB);
      host_scl = 1'b1; tick(2 * HB - 2);
      b = sda_bus;
      tick(2);
      host_scl = 1'b0; tick(HB);
   endtask

   task automatic write_byte(input logic [7:0] v, input bit glitch, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(v[i], glitch);
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic read_byte(output logic [7:0] v, input bit host_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         v[i] = b;
      end
      send_bit(host_ack ? 1'b0 : 1'b1, 1'b0);
   endtask

   task automatic wr_seq(input logic [6:0] dev, input logic [7:0] ptr, input int n,
                         input logic [7:0] d0, input logic [7:0] dstep, input bit glitch,
                         input string tag);
      logic ack;
      bus_start();
      write_byte({dev, 1'b0}, 1'b0, ack);
      check(ack, tag, "write address ack", int'(ack), 1);
      write_byte(ptr, glitch, ack);
      check(ack, tag, "pointer byte ack", int'(ack), 1);
      for (int k = 0; k < n; k++) begin
         logic [7:0] d, a;
         wr_item_t it;
         d = 8'(d0 + k * dstep);
         a = 8'(ptr + k);
         it.a = a; it.d = d;
         sb_q.push_back(it);
         exp_mem[a] = d;
         write_byte(d, glitch, ack);
         check(ack, tag, "data byte ack", int'(ack), 1);
      end
      bus_stop();
      tick(4);
   endtask

   task automatic rd_seq(input logic [6:0] dev, input logic [7:0] ptr, input int n,
                         input string tag);
      logic ack, b;
      logic [7:0] v;
      bus_start();
      write_byte({dev, 1'b0}, 1'b0, ack);
      check(ack, tag, "address ack before pointer", int'(ack), 1);
      write_byte(ptr, 1'b0, ack);
      check(ack, tag, "pointer ack", int'(ack), 1);
      bus_start();  // repeated START (R6)
      write_byte({dev, 1'b1}, 1'b0, ack);
      check(ack, "R6", "read address ack after repeated START", int'(ack), 1);
      for (int k = 0; k < n; k++) begin
         logic [7:0] a;
         a = 8'(ptr + k);
         read_byte(v, k != n - 1);
         check(v == exp_mem[a], tag, "read data", int'(v), int'(exp_mem[a]));
      end
      recv_bit(b);
      check(b == 1'b1, "R9", "line released after NACK", int'(b), 1);
      bus_stop();
      tick(4);
   endtask

   initial begin
      logic ack;
      int   w0;
      for (int i = 0; i < 256; i++) exp_mem[i] = 8'((i * 37 + 5) & 8'hFF);
      tick(5);
      rst_n = 1'b1;
      tick(3);
      check(sda_oe == 1'b0, "R10", "sda_oe after reset", int'(sda_oe), 0);
      check(reg_wr_en == 1'b0, "R10", "reg_wr_en after reset", int'(reg_wr_en), 0);

      // R3: clocked traffic with no START
      write_byte(8'h9A, 1'b0, ack);
      check(!ack, "R3", "ack without START", int'(ack), 0);
      write_byte(8'h33, 1'b0, ack);
      check(!ack, "R3", "data ack without START", int'(ack), 0);
      check(wr_cnt == 0, "R3", "writes without START", wr_cnt, 0);

      // R2: strap bit mismatch, then prefix mismatch
      bus_start();
      write_byte(8'h98, 1'b0, ack);
      check(!ack, "R2", "strap mismatch ack", int'(ack), 0);
      write_byte(8'h00, 1'b0, ack);
      check(!ack, "R2", "byte after mismatch ack", int'(ack), 0);
      write_byte(8'h55, 1'b0, ack);
      check(!ack, "R2", "second byte after mismatch ack", int'(ack), 0);
      bus_stop();
      bus_start();
      write_byte({7'h2D, 1'b0}, 1'b0, ack);
      check(!ack, "R2", "prefix mismatch ack", int'(ack), 0);
      bus_stop();
      tick(4);
      check(wr_cnt == 0, "R2", "writes after mismatch", wr_cnt, 0);

      // R1/R4: matched write of three bytes
      wr_seq(7'h4D, 8'h10, 3, 8'hA5, 8'h11, 1'b0, "R4");
      // R6/R5: pointer write, repeated START, read back
      rd_seq(7'h4D, 8'h10, 3, "R6");
      // R5: 28 sequential reads from 0x00
      rd_seq(7'h4D, 8'h00, 28, "R5");
      // R7: wrap through 0xFF
      wr_seq(7'h4D, 8'hFE, 3, 8'h11, 8'h11, 1'b0, "R7");
      rd_seq(7'h4D, 8'hFE, 3, "R7");
      // R8: glitches on every bit of pointer and data
      w0 = wr_cnt;
      wr_seq(7'h4D, 8'h40, 2, 8'hC3, 8'h5A, 1'b1, "R8");
      check(wr_cnt - w0 == 2, "R8", "strobes with glitches", wr_cnt - w0, 2);
      rd_seq(7'h4D, 8'h40, 2, "R8");
      // R1: strap low moves the address
      addr_strap = 1'b0;
      tick(4);
      wr_seq(7'h4C, 8'h80, 1, 8'h3E, 8'h00, 1'b0, "R1");
      rd_seq(7'h4C, 8'h80, 1, "R1");
      bus_start();
      write_byte({7'h4D, 1'b1}, 1'b0, ack);
      check(!ack, "R1", "old address after strap change", int'(ack), 0);
      bus_stop();
      tick(20);
      check(sb_q.size() == 0, "R4", "scoreboard drained", sb_q.size(), 0);

      done = 1'b1;
      report();
      $finish;
   end
endmodule